// File: doc/BRIEF.md
# DMA Channel Security Configuration Register

This block holds the configuration word of one DMA channel. The word is made up of a channel enable, a privileged-mode flag, a priority level, a memory-to-memory flag, a secure-mode flag and a source-security flag. It sits on a simple register bus that carries one access per clock. Each access has an address, a write strobe, write data and two attribute lines that say whether the access is secure and whether it is privileged. The read data is combinational and reflects the current address and attributes. Writes take effect at the next rising clock edge.

Every access is filtered by its attributes. A channel marked secure or privileged accepts writes only from accesses that carry the matching attribute. Only secure accesses may change the two security flags. While the channel is enabled, every field except the enable itself is frozen. The source-security flag is hidden from reads that lack the right attributes. The hardware drops the source-security flag when a secure write moves the channel back to non-secure. A forbidden write produces a one-cycle illegal-access pulse in the cycle after the write is sampled. The stored fields also drive dedicated outputs toward the channel's transfer logic.

Top module: `dma_chan_cfg`

## Requirements
- R1: After reset every stored field is 0, a read of the register address returns 0, every channel output is 0 and the illegal-access output is 0.
- R2: The secure-mode flag sits at bit 17 (1 = secure channel). Only a secure write sets or clears it. A non-secure write with bit 17 at 1 leaves the flag unchanged and pulses the illegal-access output.
- R3: The source-security flag sits at bit 18 (1 = secure transfer from the source). Reads by a secure access return the stored value at bit 18. Reads by a non-secure access always return 0 there. Bit 17 reads back for any access.
- R4: A non-secure write with bit 18 at 1 leaves the source-security flag unchanged and pulses the illegal-access output. The permitted fields of that same write are still stored.
- R5: A secure write that clears the secure-mode flag (stored 1, written 0) also clears the source-security flag, even when that write carries bit 18 at 1.
- R6: Bit 14 holds the memory-to-memory flag, and bits 13:12 hold the priority level (00 low, 01 medium, 10 high, 11 very high). A permitted write stores both. Bits 16:15 and all other unassigned bits always read 0.
- R7: The enable sits at bit 0. While the stored enable is 1, writes leave all other fields unchanged, and the enable itself can still be written. When the stored enable is 0, a single write may set the enable and load the other fields together.
- R8: When the channel is secure and the access is non-secure, or the channel is privileged and the access is unprivileged, the whole write is discarded and the illegal-access output pulses.
- R9: The privileged-mode flag sits at bit PRIV_POS (default 1). Only a privileged write may set or clear it. An unprivileged write with that bit at 1 leaves it unchanged and pulses the illegal-access output. While the flag is 1, an unprivileged read returns 0 at bit 18.
- R10: The illegal-access output is high for exactly the one cycle after an offending write is sampled. It stays low after permitted writes and when no write takes place.
- R11: A write to any address other than CFG_ADDR changes nothing, and a read of any such address returns 0.
- R12: The outputs ch_en, ch_priv, ch_prio, ch_m2m, ch_secure and ch_src_secure always equal the stored fields, whatever the attributes of the current access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_addr | input | ADDR_W | Access address |
| bus_we | input | 1 | Write strobe for the current access |
| bus_wdata | input | DATA_W | Write data |
| bus_sec | input | 1 | Access carries the secure attribute |
| bus_priv | input | 1 | Access carries the privileged attribute |
| bus_rdata | output | DATA_W | Filtered read data for the current address and attributes |
| illegal_pulse | output | 1 | One-cycle pulse after a forbidden write |
| ch_en | output | 1 | Channel enabled |
| ch_priv | output | 1 | Channel in privileged mode |
| ch_prio | output | 2 | Channel priority level |
| ch_m2m | output | 1 | Memory-to-memory mode |
| ch_secure | output | 1 | Channel in secure mode |
| ch_src_secure | output | 1 | Source side of the transfer is secure |

## Verification
Two functions can act in the same write. One is the automatic clear of the source-security flag. The other is an explicit write of 1 to that same flag: a secure write that drops the secure-mode flag while carrying bit 18 at 1 raises both. That vector is judged by reading back with secure privileged attributes, and the clear must win. A second collision mixes a partly illegal write with legal fields: a non-secure write that sets bit 18 and also loads priority and memory-to-memory. It must store the legal fields, leave bit 18 clear and pulse the illegal output, all from that single write.

// File: rtl/dma_cfg_pkg.sv
package dma_cfg_pkg;

  localparam int EN_POS   = 0;
  localparam int PRIO_LO  = 12;
  localparam int PRIO_HI  = PRIO_LO + 1;
  localparam int M2M_POS  = 14;
  localparam int SECM_POS = 17;
  localparam int SSEC_POS = 18;
  localparam int MIN_W    = SSEC_POS + 1;

  typedef enum logic [1:0] {
    PRIO_LOW   = 2'b00,
    PRIO_MED   = 2'b01,
    PRIO_HIGH  = 2'b10,
    PRIO_VHIGH = 2'b11
  } prio_e;

  typedef struct packed {
    logic  ssec;
    logic  secm;
    logic  m2m;
    prio_e prio;
    logic  privm;
    logic  en;
  } chan_cfg_t;

  typedef struct packed {
    logic  en;
    logic  privm;
    logic  m2m;
    prio_e prio;
    logic  secm;
    logic  ssec;
  } wr_bits_t;

  typedef struct packed {
    logic hit;
    logic gate_ok;
    logic ld_en;
    logic ld_fields;
    logic ld_privm;
    logic ld_secm;
    logic ld_ssec;
    logic ssec_clr;
    logic illegal;
  } wr_ctl_t;

endpackage

// File: rtl/cfg_rst_sync.sv
module cfg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic srst_n
);

  logic [STAGES-1:0] chain_q;

  genvar g;
  generate
    for (g = 0; g < STAGES; g++) begin : g_stage
      logic d;
      if (g == 0) begin : g_first
        assign d = 1'b1;
      end else begin : g_next
        assign d = chain_q[g-1];
      end
      always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) chain_q[g] <= 1'b0;
        else         chain_q[g] <= d;
      end
    end
  endgenerate

  assign srst_n = chain_q[STAGES-1];

endmodule

// File: rtl/cfg_access_filter.sv
module cfg_access_filter
  import dma_cfg_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              we,
  input  wr_bits_t          wbits,
  input  logic              sec,
  input  logic              priv,
  input  chan_cfg_t         cur,
  output wr_ctl_t           ctl
);

  logic hit;
  logic gate_ok;
  logic open_wr;
  logic cfg_open;
  logic bad_sec_bits;
  logic bad_priv_bit;

  always_comb begin
    hit          = we && (addr == CFG_ADDR);
    gate_ok      = (sec || !cur.secm) && (priv || !cur.privm);
    open_wr      = hit && gate_ok;
    cfg_open     = open_wr && !cur.en;
    bad_sec_bits = !sec && (wbits.ssec || wbits.secm);
    bad_priv_bit = !priv && wbits.privm;

    ctl.hit       = hit;
    ctl.gate_ok   = gate_ok;
    ctl.ld_en     = open_wr;
    ctl.ld_fields = cfg_open;
    ctl.ld_privm  = cfg_open && priv;
    ctl.ld_secm   = cfg_open && sec;
    ctl.ld_ssec   = cfg_open && sec;
    ctl.ssec_clr  = cfg_open && sec && cur.secm && !wbits.secm;
    ctl.illegal   = hit && (!gate_ok || bad_sec_bits || bad_priv_bit);
  end

endmodule

// File: rtl/cfg_field_regs.sv
module cfg_field_regs
  import dma_cfg_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  wr_ctl_t   ctl,
  input  wr_bits_t  wbits,
  input  logic      sec,
  output chan_cfg_t cfg_q,
  output logic      illegal_q
);

  chan_cfg_t cfg_d;
  logic      cfg_ce;
  logic      illegal_d;

  always_comb begin
    cfg_d = cfg_q;
    if (ctl.ld_en)     cfg_d.en    = wbits.en;
    if (ctl.ld_fields) begin
      cfg_d.m2m  = wbits.m2m;
      cfg_d.prio = wbits.prio;
    end
    if (ctl.ld_privm)  cfg_d.privm = wbits.privm;
    if (ctl.ld_secm)   cfg_d.secm  = wbits.secm;
    if (ctl.ld_ssec)   cfg_d.ssec  = wbits.ssec;
    if (ctl.ssec_clr)  cfg_d.ssec  = 1'b0;
    cfg_ce    = ctl.ld_en;
    illegal_d = ctl.illegal;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg_q <= '0;
    end else if (cfg_ce) begin
      cfg_q <= cfg_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) illegal_q <= 1'b0;
    else        illegal_q <= illegal_d;
  end

  // R4
  ssec_nonsec_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hit && !sec) |=> $stable(cfg_q.ssec));

  // R5
  ssec_autoclr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hit && sec && ctl.gate_ok && cfg_q.secm && !cfg_q.en && !wbits.secm) |=> !cfg_q.ssec);

  // R7
  frozen_fields_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hit && cfg_q.en) |=> $stable({cfg_q.ssec, cfg_q.secm, cfg_q.m2m, cfg_q.prio, cfg_q.privm}));

  // R8
  denied_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl.hit && !ctl.gate_ok) |=> $stable(cfg_q));

  // R10
  pulse_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    illegal_q |-> $past(ctl.hit));

endmodule

// File: rtl/cfg_read_mux.sv
module cfg_read_mux
  import dma_cfg_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int PRIV_POS = 1,
  parameter logic [ADDR_W-1:0] CFG_ADDR = '0
) (
  input  logic [ADDR_W-1:0] addr,
  input  logic              sec,
  input  logic              priv,
  input  chan_cfg_t         cfg,
  output logic [DATA_W-1:0] rdata
);

  logic              rd_hit;
  logic              ssec_vis;
  logic [DATA_W-1:0] word;

  always_comb begin
    rd_hit   = (addr == CFG_ADDR);
    ssec_vis = sec && (priv || !cfg.privm);
    word                    = '0;
    word[EN_POS]            = cfg.en;
    word[PRIV_POS]          = cfg.privm;
    word[PRIO_HI:PRIO_LO]   = cfg.prio;
    word[M2M_POS]           = cfg.m2m;
    word[SECM_POS]          = cfg.secm;
    word[SSEC_POS]          = cfg.ssec && ssec_vis;
    rdata = rd_hit ? word : '0;
  end

  // R3
  always_comb begin
    if (sec === 1'b0) begin
      ssec_read_hide_chk: assert (rdata[SSEC_POS] == 1'b0);
    end
  end

endmodule

// File: rtl/dma_chan_cfg.sv
module dma_chan_cfg
  import dma_cfg_pkg::*;
#(
  parameter int ADDR_W      = 8,
  parameter int DATA_W      = 32,
  parameter int PRIV_POS    = 1,
  parameter int SYNC_STAGES = 2,
  parameter logic [ADDR_W-1:0] CFG_ADDR = 8'h10
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_we,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_sec,
  input  logic              bus_priv,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              illegal_pulse,
  output logic              ch_en,
  output logic              ch_priv,
  output logic [1:0]        ch_prio,
  output logic              ch_m2m,
  output logic              ch_secure,
  output logic              ch_src_secure
);

  logic      srst_n;
  wr_bits_t  wbits;
  wr_ctl_t   ctl;
  chan_cfg_t cfg_q;
  logic      unused_wdata;

  always_comb begin
    wbits.en    = bus_wdata[EN_POS];
    wbits.privm = bus_wdata[PRIV_POS];
    wbits.m2m   = bus_wdata[M2M_POS];
    wbits.prio  = prio_e'(bus_wdata[PRIO_HI:PRIO_LO]);
    wbits.secm  = bus_wdata[SECM_POS];
    wbits.ssec  = bus_wdata[SSEC_POS];
  end
  assign unused_wdata = ^bus_wdata;

  cfg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk    (clk),
    .arst_n (rst_n),
    .srst_n (srst_n)
  );

  cfg_access_filter #(.ADDR_W(ADDR_W), .CFG_ADDR(CFG_ADDR)) u_filt (
    .addr  (bus_addr),
    .we    (bus_we),
    .wbits (wbits),
    .sec   (bus_sec),
    .priv  (bus_priv),
    .cur   (cfg_q),
    .ctl   (ctl)
  );

  cfg_field_regs u_regs (
    .clk       (clk),
    .rst_n     (srst_n),
    .ctl       (ctl),
    .wbits     (wbits),
    .sec       (bus_sec),
    .cfg_q     (cfg_q),
    .illegal_q (illegal_pulse)
  );

  cfg_read_mux #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .PRIV_POS (PRIV_POS),
    .CFG_ADDR (CFG_ADDR)
  ) u_rd (
    .addr  (bus_addr),
    .sec   (bus_sec),
    .priv  (bus_priv),
    .cfg   (cfg_q),
    .rdata (bus_rdata)
  );

  assign ch_en         = cfg_q.en;
  assign ch_priv       = cfg_q.privm;
  assign ch_prio       = cfg_q.prio;
  assign ch_m2m        = cfg_q.m2m;
  assign ch_secure     = cfg_q.secm;
  assign ch_src_secure = cfg_q.ssec;

endmodule

// File: tb/sim_dma_chan_cfg.sv
module sim_dma_chan_cfg;

  localparam int CLK_P  = 10;
  localparam int NVEC   = 18;
  localparam logic [7:0] A_CFG   = 8'h10;
  localparam logic [7:0] A_OTHER = 8'h14;

  typedef struct packed {
    logic        we;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic        wsec;
    logic        wpriv;
    logic        rsec;
    logic        rpriv;
    logic [31:0] exp_rd;
    logic        exp_ill;
    logic [7:0]  req;
  } vec_t;

  // Field positions: en 0, privileged mode 1, priority 13:12, m2m 14,
  // secure mode 17, source security 18.
  localparam vec_t VECS [NVEC] = '{
    // R6 reserved bits and bit 5 dropped, m2m and priority stored
    '{1'b1, A_CFG,   32'h0001_F020, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0000_7000, 1'b0, 8'd6},
    // R4 non-secure set of bit 18 refused, other fields still written
    '{1'b1, A_CFG,   32'h0004_4000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_4000, 1'b1, 8'd4},
    // R2 secure write sets secure mode and source security
    '{1'b1, A_CFG,   32'h0006_1000, 1'b1, 1'b0, 1'b1, 1'b0, 32'h0006_1000, 1'b0, 8'd2},
    // R3 non-secure read hides bit 18
    '{1'b0, A_CFG,   32'h0000_0000, 1'b0, 1'b0, 1'b0, 1'b0, 32'h0002_1000, 1'b0, 8'd3},
    // R8 non-secure write to a secure channel discarded
    '{1'b1, A_CFG,   32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0006_1000, 1'b1, 8'd8},
    // R5 clear of secure mode wins over bit 18 written 1
    '{1'b1, A_CFG,   32'h0004_0000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 8'd5},
    // R9 privileged secure write sets privileged mode
    '{1'b1, A_CFG,   32'h0006_0002, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0006_0002, 1'b0, 8'd9},
    // R8 unprivileged write to a privileged channel discarded
    '{1'b1, A_CFG,   32'h0000_0000, 1'b1, 1'b0, 1'b1, 1'b1, 32'h0006_0002, 1'b1, 8'd8},
    // R9 unprivileged read hides bit 18 on a privileged channel
    '{1'b0, A_CFG,   32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b0, 32'h0002_0002, 1'b0, 8'd9},
    // R7 enable and fields loaded in one write
    '{1'b1, A_CFG,   32'h0006_3003, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0006_3003, 1'b0, 8'd7},
    // R7 fields frozen while enabled
    '{1'b1, A_CFG,   32'h0000_4001, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0006_3003, 1'b0, 8'd7},
    // R7 enable cleared, fields still frozen in that write
    '{1'b1, A_CFG,   32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0006_3002, 1'b0, 8'd7},
    // R11 other address: no effect, reads 0
    '{1'b1, A_OTHER, 32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 8'd11},
    // R11 register unchanged by that write
    '{1'b0, A_CFG,   32'h0000_0000, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0006_3002, 1'b0, 8'd11},
    // R5 secure privileged write clears everything
    '{1'b1, A_CFG,   32'h0000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 32'h0000_0000, 1'b0, 8'd5},
    // R9 unprivileged set of privileged mode refused
    '{1'b1, A_CFG,   32'h0000_0002, 1'b0, 1'b0, 1'b1, 1'b1, 32'h0000_0000, 1'b1, 8'd9},
    // R9 privileged non-secure set accepted
    '{1'b1, A_CFG,   32'h0000_0002, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0002, 1'b0, 8'd9},
    // R2 non-secure set of secure mode refused
    '{1'b1, A_CFG,   32'h0002_0002, 1'b0, 1'b1, 1'b1, 1'b1, 32'h0000_0002, 1'b1, 8'd2}
  };

  logic        clk;
  logic        rst_n;
  logic [7:0]  bus_addr;
  logic        bus_we;
  logic [31:0] bus_wdata;
  logic        bus_sec;
  logic        bus_priv;
  logic [31:0] bus_rdata;
  logic        illegal_pulse;
  logic        ch_en;
  logic        ch_priv;
  logic [1:0]  ch_prio;
  logic        ch_m2m;
  logic        ch_secure;
  logic        ch_src_secure;

  int n_chk;
  int n_fail;

  dma_chan_cfg u0 (
    .clk           (clk),
    .rst_n         (rst_n),
    .bus_addr      (bus_addr),
    .bus_we        (bus_we),
    .bus_wdata     (bus_wdata),
    .bus_sec       (bus_sec),
    .bus_priv      (bus_priv),
    .bus_rdata     (bus_rdata),
    .illegal_pulse (illegal_pulse),
    .ch_en         (ch_en),
    .ch_priv       (ch_priv),
    .ch_prio       (ch_prio),
    .ch_m2m        (ch_m2m),
    .ch_secure     (ch_secure),
    .ch_src_secure (ch_src_secure)
  );

  initial clk = 1'b0;
  always #(CLK_P/2) clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idle();
    bus_we    = 1'b0;
    bus_wdata = '0;
  endtask

  task automatic write_cfg(input logic [31:0] d, input logic s, input logic p);
    @(negedge clk);
    bus_addr  = A_CFG;
    bus_we    = 1'b1;
    bus_wdata = d;
    bus_sec   = s;
    bus_priv  = p;
    @(negedge clk);
    idle();
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
  endtask

  initial begin
    #(CLK_P * 20000);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk     = 0;
    n_fail    = 0;
    bus_addr  = A_CFG;
    bus_sec   = 1'b1;
    bus_priv  = 1'b1;
    idle();
    do_reset();

    // R1 reset state
    #1;
    check("R1 rdata", bus_rdata, 32'h0);
    check("R1 illegal", {31'b0, illegal_pulse}, 32'h0);
    check("R1 outputs", {25'b0, ch_en, ch_priv, ch_prio, ch_m2m, ch_secure, ch_src_secure}, 32'h0);

    for (int i = 0; i < NVEC; i++) begin
      @(negedge clk);
      bus_addr  = VECS[i].addr;
      bus_we    = VECS[i].we;
      bus_wdata = VECS[i].wdata;
      bus_sec   = VECS[i].wsec;
      bus_priv  = VECS[i].wpriv;
      @(negedge clk);
      n_chk++;
      if (illegal_pulse !== VECS[i].exp_ill) begin
        n_fail++;
        $display("FAIL R%0d vec %0d illegal actual=%b expected=%b",
                 VECS[i].req, i, illegal_pulse, VECS[i].exp_ill);
      end
      idle();
      bus_sec  = VECS[i].rsec;
      bus_priv = VECS[i].rpriv;
      #1;
      n_chk++;
      if (bus_rdata !== VECS[i].exp_rd) begin
        n_fail++;
        $display("FAIL R%0d vec %0d rdata actual=%h expected=%h",
                 VECS[i].req, i, bus_rdata, VECS[i].exp_rd);
      end
      @(negedge clk);
      // R10 pulse gone one cycle later
      check("R10 pulse width", {31'b0, illegal_pulse}, 32'h0);
    end

    // R12 outputs follow stored fields under a non-secure unprivileged access
    write_cfg(32'h0000_0000, 1'b0, 1'b1);
    write_cfg(32'h0006_6003, 1'b1, 1'b1);
    bus_sec  = 1'b0;
    bus_priv = 1'b0;
    #1;
    check("R12 outputs", {25'b0, ch_en, ch_priv, ch_prio, ch_m2m, ch_secure, ch_src_secure},
          {25'b0, 1'b1, 1'b1, 2'b10, 1'b1, 1'b1, 1'b1});
    check("R10 no pulse after permitted writes", {31'b0, illegal_pulse}, 32'h0);

    // R10 back-to-back offending writes: one pulse per write, then low
    @(negedge clk);
    bus_addr  = A_CFG;
    bus_we    = 1'b1;
    bus_wdata = 32'h0;
    bus_sec   = 1'b0;
    bus_priv  = 1'b0;
    @(negedge clk);
    check("R10 first pulse", {31'b0, illegal_pulse}, 32'h1);
    @(negedge clk);
    idle();
    check("R10 second pulse", {31'b0, illegal_pulse}, 32'h1);
    @(negedge clk);
    check("R10 pulse end", {31'b0, illegal_pulse}, 32'h0);
    bus_sec  = 1'b1;
    bus_priv = 1'b1;
    #1;
    check("R8 denied writes kept state", bus_rdata, 32'h0006_6003);

    // R1 reset in the middle clears stored state
    do_reset();
    #1;
    check("R1 rdata after reset", bus_rdata, 32'h0);
    check("R1 outputs after reset", {25'b0, ch_en, ch_priv, ch_prio, ch_m2m, ch_secure, ch_src_secure}, 32'h0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule